// File: doc/BRIEF.md
# Edge port interrupt detector

This block watches seven external interrupt pins, numbered 1 to 7, and turns them into seven request lines for an interrupt controller. Software configures each pin through a small set of byte-addressed registers: a direction bit, an interrupt enable bit, a 2-bit sensing mode and a status flag. The pins are synchronized into the clock domain and then judged per the selected mode: active-low level, rising edge, falling edge or both edges. In the edge modes a detected edge is latched into a sticky flag that software clears by writing 1. Bit 0 of every per-pin register is reserved, and there is no pin 0.

Each pin is handled by its own three-state machine. PS_QUIET means nothing is pending. PS_LOW_SEEN means a level-mode pin is low. PS_CAUGHT means an edge has been latched.

In level mode the next state is PS_LOW_SEEN when the synchronized pin is low and PS_QUIET when it is high. In an edge mode a qualifying edge moves any state to PS_CAUGHT. A clear write with no edge in the same cycle moves PS_CAUGHT to PS_QUIET. PS_LOW_SEEN falls back to PS_QUIET when the pin is no longer in level mode. The flag reads 1 in any state other than PS_QUIET.

Top module: `edgeport_irq_detect`

## Requirements
- R1: After reset every register reads 0, so every pin is a level-mode, disabled input with its flag clear and its request low.
- R2: Byte address map. Offsets 0 and 1 hold mode bits 7:0 and 15:8. Offset 2 holds direction. Offset 3 holds enable. Offset 4 holds the flags. A byte write places wr_data[7:0] at wr_addr. A halfword write ignores wr_addr[0] and places wr_data[7:0] at the even offset and wr_data[15:8] at the odd offset. rd_data returns the odd byte in bits 15:8 and the even byte in bits 7:0.
- R3: Bit 0 of direction, enable and flags, and mode bits 1:0, are reserved. Writes to them are ignored, they read 0, pin_i[0] has no effect, and irq_req[0] stays 0.
- R4: The mode of pin p sits at bits 2p+1:2p: 00 level, 01 rising edge, 10 falling edge, 11 both edges.
- R5: In level mode the flag and the request follow the synchronized pin while it is low, drop when it returns high, and a 1 written to the flag has no effect.
- R6: In an edge mode a qualifying edge sets the flag. The flag and the request stay set until software writes 1 to that flag bit. Writing 0 leaves the flag unchanged.
- R7: A pin change reaches the flag and the request on the third rising clock edge after it occurs, and not before.
- R8: With the enable bit 0, the request is held low while the flag still records events. Setting the enable bit then raises the request.
- R9: With the direction bit 1 (pin used as an output), the request is held low.
- R10: When a clear write and a new qualifying edge fall in the same cycle, the flag stays set.
- R11: An edge of the opposite polarity (falling in rising mode, rising in falling mode) does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | External pins, bit 0 unused |
| wr_en | input | 1 | Write strobe |
| wr_half | input | 1 | 1 selects a halfword write, 0 a byte write |
| wr_addr | input | 3 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read byte offset, bit 0 ignored |
| rd_data | output | 16 | Read halfword, combinational |
| irq_req | output | 8 | Request per pin to the interrupt controller, bit 0 always 0 |

## Verification
A pin change passes two synchronizer flops and the state register, so its effect on the flag and the request is due on the third rising edge. The bench drives each pin on a falling edge and samples on the falling edge that follows the third rising edge. It also samples one edge earlier to show that nothing arrives sooner. A register write is driven for one cycle and read back on the falling edge just after the rising edge that captures it. The same-cycle race is built by placing the clear write in exactly the cycle in which the synchronized edge is seen.

// File: rtl/edgeport_pkg.sv
`timescale 1ns/1ps
package edgeport_pkg;
    localparam int EP_PINS   = 8;              // register width, bit 0 reserved
    localparam int EP_MODE_W = 2;
    localparam int EP_ADDR_W = 3;
    localparam int EP_BYTES  = 6;              // decoded byte offsets

    localparam logic [EP_ADDR_W-1:0] OFS_MODE_LO = 3'd0;
    localparam logic [EP_ADDR_W-1:0] OFS_MODE_HI = 3'd1;
    localparam logic [EP_ADDR_W-1:0] OFS_DIR     = 3'd2;
    localparam logic [EP_ADDR_W-1:0] OFS_EN      = 3'd3;
    localparam logic [EP_ADDR_W-1:0] OFS_FLAG    = 3'd4;

    typedef enum logic [1:0] {
        MD_LEVEL = 2'b00,
        MD_RISE  = 2'b01,
        MD_FALL  = 2'b10,
        MD_BOTH  = 2'b11
    } sense_mode_e;

    typedef enum logic [1:0] {
        PS_QUIET    = 2'b00,
        PS_LOW_SEEN = 2'b01,
        PS_CAUGHT   = 2'b10
    } pin_state_e;
endpackage

// File: rtl/edgeport_sync.sv
`timescale 1ns/1ps
module edgeport_sync #(
    parameter int               WIDTH   = 8,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/edgeport_regs.sv
`timescale 1ns/1ps
module edgeport_regs
    import edgeport_pkg::*;
#(
    parameter int PIN_CNT = EP_PINS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_half,
    input  logic [EP_ADDR_W-1:0]          wr_addr,
    input  logic [15:0]                   wr_data,
    input  logic [EP_ADDR_W-1:0]          rd_addr,
    input  logic [PIN_CNT-1:0]            flag_i,
    output logic [15:0]                   rd_data,
    output logic [EP_MODE_W*PIN_CNT-1:0]  mode_o,
    output logic [PIN_CNT-1:0]            dir_o,
    output logic [PIN_CNT-1:0]            en_o,
    output logic [PIN_CNT-1:0]            clr_o
);
    localparam int MODE_BITS = EP_MODE_W * PIN_CNT;
    localparam logic [PIN_CNT-1:0]   LIVE_MASK = {{(PIN_CNT-1){1'b1}}, 1'b0};
    localparam logic [MODE_BITS-1:0] MODE_MASK = {{(MODE_BITS-EP_MODE_W){1'b1}}, {EP_MODE_W{1'b0}}};

    logic [EP_BYTES-1:0]      lane_we;
    logic [EP_BYTES-1:0][7:0] lane_data;
    logic [MODE_BITS-1:0]     mode_q;
    logic [PIN_CNT-1:0]       dir_q;
    logic [PIN_CNT-1:0]       en_q;

    // byte lane decode: a halfword covers the even offset and its odd neighbour
    for (genvar b = 0; b < EP_BYTES; b++) begin : g_lane
        localparam logic [EP_ADDR_W-1:0] OFS = EP_ADDR_W'(b);
        assign lane_we[b] = wr_en && (wr_half ? (wr_addr[EP_ADDR_W-1:1] == OFS[EP_ADDR_W-1:1])
                                              : (wr_addr == OFS));
        if (b % 2 == 1) begin : g_odd
            assign lane_data[b] = wr_half ? wr_data[15:8] : wr_data[7:0];
        end else begin : g_even
            assign lane_data[b] = wr_data[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
        end else begin
            if (lane_we[OFS_MODE_LO]) mode_q[7:0]  <= lane_data[OFS_MODE_LO] & MODE_MASK[7:0];
            if (lane_we[OFS_MODE_HI]) mode_q[15:8] <= lane_data[OFS_MODE_HI] & MODE_MASK[15:8];
            if (lane_we[OFS_DIR])     dir_q        <= lane_data[OFS_DIR] & LIVE_MASK;
            if (lane_we[OFS_EN])      en_q         <= lane_data[OFS_EN] & LIVE_MASK;
        end
    end

    // write-one-to-clear pulse, valid only in the cycle of the write
    assign clr_o = lane_we[OFS_FLAG] ? (lane_data[OFS_FLAG] & LIVE_MASK) : '0;

    function automatic logic [7:0] byte_at(input logic [EP_ADDR_W-1:0] ofs);
        unique case (ofs)
            OFS_MODE_LO: byte_at = mode_q[7:0];
            OFS_MODE_HI: byte_at = mode_q[15:8];
            OFS_DIR:     byte_at = dir_q;
            OFS_EN:      byte_at = en_q;
            OFS_FLAG:    byte_at = flag_i & LIVE_MASK;
            default:     byte_at = 8'h00;
        endcase
    endfunction

    assign rd_data = {byte_at({rd_addr[EP_ADDR_W-1:1], 1'b1}),
                      byte_at({rd_addr[EP_ADDR_W-1:1], 1'b0})};

    logic rd_lsb_unused;
    assign rd_lsb_unused = rd_addr[0];

    assign mode_o = mode_q;
    assign dir_o  = dir_q;
    assign en_o   = en_q;

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[OFS_DIR] |=> $stable(dir_q)); // R2
    AST_MODE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we[OFS_MODE_LO] |=> (mode_q[1:0] == 2'b00)); // R3
endmodule

// File: rtl/edgeport_pin_fsm.sv
`timescale 1ns/1ps
module edgeport_pin_fsm
    import edgeport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_sync_i,
    input  logic [EP_MODE_W-1:0] mode_i,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic                 dir_i,
    output logic                 flag_o,
    output logic                 req_o
);
    sense_mode_e mode;
    pin_state_e  state_q, state_d;
    logic        prev_q;
    logic        rise_hit, fall_hit, edge_hit;

    assign mode     = sense_mode_e'(mode_i);
    assign rise_hit =  pin_sync_i & ~prev_q;
    assign fall_hit = ~pin_sync_i &  prev_q;

    always_comb begin
        unique case (mode)
            MD_LEVEL: edge_hit = 1'b0;
            MD_RISE:  edge_hit = rise_hit;
            MD_FALL:  edge_hit = fall_hit;
            MD_BOTH:  edge_hit = rise_hit | fall_hit;
            default:  edge_hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_QUIET;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_sync_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (mode == MD_LEVEL) begin
            state_d = pin_sync_i ? PS_QUIET : PS_LOW_SEEN;
        end else begin
            unique case (state_q)
                PS_QUIET:    if (edge_hit) state_d = PS_CAUGHT;
                PS_LOW_SEEN: state_d = edge_hit ? PS_CAUGHT : PS_QUIET;
                PS_CAUGHT:   if (!edge_hit && clr_i) state_d = PS_QUIET;
                default:     state_d = PS_QUIET;
            endcase
        end
    end

    // outputs
    always_comb begin
        flag_o = (state_q != PS_QUIET);
        req_o  = flag_o && en_i && !dir_i;
    end

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_LEVEL && edge_hit) |=> (state_q == PS_CAUGHT)); // R10
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_LEVEL && state_q == PS_CAUGHT && !clr_i) |=> (state_q == PS_CAUGHT)); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_LEVEL && state_q == PS_CAUGHT && clr_i && !edge_hit) |=> (state_q == PS_QUIET)); // R6
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_LEVEL && !pin_sync_i) |=> flag_o); // R5
    AST_WRONG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RISE && state_q == PS_QUIET && !rise_hit) |=> (state_q == PS_QUIET)); // R11
endmodule

// File: rtl/edgeport_irq_detect.sv
`timescale 1ns/1ps
module edgeport_irq_detect
    import edgeport_pkg::*;
#(
    parameter int PIN_CNT     = EP_PINS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_CNT-1:0]   pin_i,
    input  logic                 wr_en,
    input  logic                 wr_half,
    input  logic [EP_ADDR_W-1:0] wr_addr,
    input  logic [15:0]          wr_data,
    input  logic [EP_ADDR_W-1:0] rd_addr,
    output logic [15:0]          rd_data,
    output logic [PIN_CNT-1:0]   irq_req
);
    localparam int MODE_BITS = EP_MODE_W * PIN_CNT;

    logic [PIN_CNT-1:0]   pin_sync;
    logic [MODE_BITS-1:0] mode;
    logic [PIN_CNT-1:0]   dir, en, clr, flags;

    edgeport_sync #(
        .WIDTH  (PIN_CNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PIN_CNT{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    edgeport_regs #(.PIN_CNT(PIN_CNT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_half(wr_half),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .flag_i (flags),
        .rd_data(rd_data),
        .mode_o (mode),
        .dir_o  (dir),
        .en_o   (en),
        .clr_o  (clr)
    );

    assign flags[0]   = 1'b0;
    assign irq_req[0] = 1'b0;

    for (genvar p = 1; p < PIN_CNT; p++) begin : g_pin
        edgeport_pin_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync_i(pin_sync[p]),
            .mode_i    (mode[EP_MODE_W*p +: EP_MODE_W]),
            .clr_i     (clr[p]),
            .en_i      (en[p]),
            .dir_i     (dir[p]),
            .flag_o    (flags[p]),
            .req_o     (irq_req[p])
        );

        AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[p] |-> (en[p] && !dir[p] && flags[p])); // R9
    end

    logic rsvd_unused;
    assign rsvd_unused = ^{pin_sync[0], mode[EP_MODE_W-1:0], dir[0], en[0], clr[0]};
endmodule

// File: tb/tb_edgeport_irq_detect.sv
`timescale 1ns/1ps
module tb_edgeport_irq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'hFF;
    logic        wr_en = 1'b0;
    logic        wr_half = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    edgeport_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .wr_en(wr_en), .wr_half(wr_half), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req)
    );

    typedef struct {
        logic [2:0]  addr;
        logic [15:0] rd;
        logic [7:0]  req;
        string       tag;
    } chk_item_t;

    chk_item_t sb[$];
    chk_item_t cur;

    // monitor: pops expected items and compares at the ports
    initial begin
        forever begin
            wait (sb.size() != 0);
            cur = sb.pop_front();
            rd_addr = cur.addr;
            #1;
            n_chk++;
            if (rd_data !== cur.rd || irq_req !== cur.req) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h irq_req=%h expected rd_data=%h irq_req=%h",
                         cur.tag, rd_data, irq_req, cur.rd, cur.req);
            end
        end
    end

    task automatic expect_at(input logic [2:0] a, input logic [15:0] rd,
                             input logic [7:0] req, input string tag);
        chk_item_t it;
        it.addr = a; it.rd = rd; it.req = req; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
        #2;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one write from a falling edge to the next
    task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit half);
        wr_en = 1'b1; wr_half = half; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_half = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        expect_at(3'd0, 16'h0000, 8'h00, "R1 mode after reset");
        expect_at(3'd2, 16'h0000, 8'h00, "R1 dir/en after reset");
        expect_at(3'd4, 16'h0000, 8'h00, "R1 flags after reset");

        // R2 R3 halfword and byte writes, reserved bits
        wr(3'd0, 16'hA5F7, 1'b1);
        expect_at(3'd0, 16'hA5F4, 8'h00, "R2 R3 halfword mode write");
        wr(3'd1, 16'h003C, 1'b0);
        expect_at(3'd1, 16'h3CF4, 8'h00, "R2 byte write odd offset");
        wr(3'd2, 16'h00FF, 1'b0);
        wr(3'd3, 16'h0001, 1'b0);
        expect_at(3'd2, 16'h00FE, 8'h00, "R2 R3 byte writes dir/en");

        // setup: all level mode, all inputs, pins 1..7 enabled
        wr(3'd0, 16'h0000, 1'b1);
        wr(3'd3, 16'hFE00, 1'b1);
        expect_at(3'd2, 16'hFE00, 8'h00, "R2 halfword at odd addr aligns down");

        // R5 R7 level mode on pin 3
        pin_i[3] = 1'b0;
        cyc(2);
        expect_at(3'd4, 16'h0000, 8'h00, "R7 level not before third edge");
        cyc(1);
        expect_at(3'd4, 16'h0008, 8'h08, "R5 R7 level low asserts");
        wr(3'd4, 16'h0008, 1'b0);
        expect_at(3'd4, 16'h0008, 8'h08, "R5 clear write ignored in level");
        pin_i[3] = 1'b1;
        cyc(3);
        expect_at(3'd4, 16'h0000, 8'h00, "R5 level high releases");

        // R4 R6 R11 rising mode on pin 2
        wr(3'd0, 16'h0010, 1'b1);
        pin_i[2] = 1'b0;
        cyc(3);
        expect_at(3'd4, 16'h0000, 8'h00, "R11 falling ignored in rising mode");
        pin_i[2] = 1'b1;
        cyc(2);
        expect_at(3'd4, 16'h0000, 8'h00, "R7 edge not before third edge");
        cyc(1);
        expect_at(3'd4, 16'h0004, 8'h04, "R4 R6 rising edge caught");
        cyc(5);
        expect_at(3'd4, 16'h0004, 8'h04, "R6 flag sticky");
        wr(3'd4, 16'h00FB, 1'b0);
        expect_at(3'd4, 16'h0004, 8'h04, "R6 zero write keeps flag");
        wr(3'd4, 16'h0004, 1'b0);
        expect_at(3'd4, 16'h0000, 8'h00, "R6 one write clears flag");

        // R4 R8 R9 R11 falling mode on pin 7
        wr(3'd0, 16'h8000, 1'b1);
        pin_i[7] = 1'b0;
        cyc(3);
        expect_at(3'd4, 16'h0080, 8'h80, "R4 falling edge caught");
        wr(3'd2, 16'h7E00, 1'b1);
        expect_at(3'd4, 16'h0080, 8'h00, "R8 disabled request held low");
        pin_i[7] = 1'b1;
        cyc(3);
        expect_at(3'd4, 16'h0080, 8'h00, "R11 rising ignored in falling mode");
        wr(3'd2, 16'hFE80, 1'b1);
        expect_at(3'd4, 16'h0080, 8'h00, "R9 output pin no request");
        wr(3'd2, 16'hFE00, 1'b1);
        expect_at(3'd4, 16'h0080, 8'h80, "R8 enable raises request");
        wr(3'd4, 16'h0080, 1'b0);
        expect_at(3'd4, 16'h0000, 8'h00, "R6 clear pin 7");

        // R8 flag records while disabled
        wr(3'd2, 16'h7E00, 1'b1);
        pin_i[7] = 1'b0;
        cyc(3);
        expect_at(3'd4, 16'h0080, 8'h00, "R8 flag sets while disabled");
        wr(3'd4, 16'h0080, 1'b0);
        wr(3'd2, 16'hFE00, 1'b1);
        pin_i[7] = 1'b1;

        // R4 R10 both edges on pin 1
        wr(3'd0, 16'h000C, 1'b1);
        pin_i[1] = 1'b0;
        cyc(3);
        expect_at(3'd4, 16'h0002, 8'h02, "R4 both mode falling caught");
        pin_i[1] = 1'b1;
        cyc(2);
        wr(3'd4, 16'h0002, 1'b0);   // captured in the cycle of the edge
        expect_at(3'd4, 16'h0002, 8'h02, "R10 edge wins over clear");
        wr(3'd4, 16'h0002, 1'b0);
        expect_at(3'd4, 16'h0000, 8'h00, "R6 clear after race");

        // R3 pin 0 and reserved bits have no effect
        wr(3'd0, 16'h0003, 1'b1);
        wr(3'd3, 16'h00FF, 1'b0);
        pin_i[0] = 1'b0;
        cyc(4);
        expect_at(3'd2, 16'hFE00, 8'h00, "R3 pin 0 raises nothing");
        expect_at(3'd0, 16'h0000, 8'h00, "R3 mode bits 1:0 stay 0");
        wr(3'd4, 16'h0001, 1'b0);
        expect_at(3'd4, 16'h0000, 8'h00, "R3 flag bit 0 reads 0");

        // R1 reset in mid-run
        pin_i[5] = 1'b0;
        cyc(3);
        expect_at(3'd4, 16'h0020, 8'h20, "R5 pin 5 level before reset");
        rst_n = 1'b0;
        cyc(2);
        expect_at(3'd2, 16'h0000, 8'h00, "R1 reset clears dir/en");
        rst_n = 1'b1;
        cyc(4);
        expect_at(3'd4, 16'h0020, 8'h00, "R1 disabled after reset");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule